// File: doc/BRIEF.md
# LZ Match Results Selector

This block sits after the comparison array of a sliding-window LZ compressor. Once a search begins, it receives one candidate match length per clock. Each candidate belongs to the next dictionary position in order. The block keeps the longest length seen so far and the position where that length first appeared. It reports the pair as the codeword fields. No position tag travels with the lengths. A local counter supplies the position, because the cycle in which a length arrives tells which position it belongs to.

A one-cycle start pulse opens a new search and clears all search state. A search ends in one of two ways. In the first, the length for the last dictionary position (DICT_LEN - LOOK_LEN) has been taken, and a ready strobe marks the codeword. In the second, the stored length reaches the full look-ahead length LOOK_LEN, and a done strobe ends the search early so that the next encoding step can begin at once. Both strobes last one cycle. After a strobe the codeword fields hold and further lengths are ignored until the next start.

Top module: `lzmr_top`

## Requirements
- R1: After reset, best_len_o and pos_o are 0 and ready_o and done_o are low.
- R2: In the cycle after start_i is sampled, best_len_o and pos_o read 0. The len_i value present in the start cycle is ignored.
- R3: The first len_i sampled after start belongs to position 0. Each later sample belongs to the next position. The position never exceeds DICT_LEN - LOOK_LEN.
- R4: A sampled len_i that is strictly greater than the stored length replaces it, and its position is stored in pos_o. An equal length leaves both unchanged, so ties keep the earliest position.
- R5: When no full match occurs, ready_o pulses in the cycle right after the length for position DICT_LEN - LOOK_LEN is sampled, which is (DICT_LEN - LOOK_LEN) + 1 cycles after the start edge. pos_o and best_len_o then hold the longest match.
- R6: When a sampled length makes the stored length equal LOOK_LEN, done_o pulses in the next cycle with best_len_o = LOOK_LEN and pos_o = that position. No later position is scanned.
- R7: A full-length match at the last position makes ready_o and done_o pulse in the same cycle.
- R8: ready_o and done_o are single-cycle pulses. After either one, len_i is ignored and the outputs hold until the next start.
- R9: A start pulse during a search abandons it and begins a new search from position 0 with the length cleared.
- R10: best_len_o is $clog2(LOOK_LEN)+1 bits wide, so that the value LOOK_LEN fits. pos_o is $clog2(DICT_LEN-LOOK_LEN+1) bits wide. Valid len_i values are 0 to LOOK_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that opens a new search |
| len_i | input | LW | Candidate match length for the current position |
| pos_o | output | PW | Position of the longest match (codeword pointer) |
| best_len_o | output | LW | Longest match length found |
| ready_o | output | 1 | Pulse: whole dictionary searched |
| done_o | output | 1 | Pulse: full-length match ended the search |

## Verification
The early-termination path and the end-of-window path can fire in the same cycle. This happens when the first full-length match lands exactly on the last dictionary position. The bench provokes it with a vector that places a length of LOOK_LEN at position DICT_LEN - LOOK_LEN and zeros elsewhere. It then requires both strobes in the same cycle, exactly (DICT_LEN - LOOK_LEN) + 1 cycles after start, with that position and length on the outputs. Other vectors place the full match earlier, to check that done appears alone and sooner, or keep lengths below LOOK_LEN, to check that ready appears alone at the window end.

// File: rtl/lzmr_pkg.sv
package lzmr_pkg;

    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_e;

endpackage

// File: rtl/lzmr_pos_count.sv
module lzmr_pos_count #(
    parameter int LAST_POS = 32,
    parameter int PW       = 6
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          step_i,
    output logic [PW-1:0] cnt_o,
    output logic          last_o
);

    localparam logic [PW-1:0] LastVal = PW'(LAST_POS);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (step_i && (st_q.cnt != LastVal)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign last_o = (st_q.cnt == LastVal);

    // R3: the position never runs past the window end
    assert_pos_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= LastVal);

    // R3: a step without clear advances the position by exactly one
    assert_pos_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !clr_i && !last_o) |=> (cnt_o == $past(cnt_o) + 1'b1));

endmodule

// File: rtl/lzmr_best_keep.sv
module lzmr_best_keep #(
    parameter int LW = 4,
    parameter int PW = 6
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          upd_i,
    input  logic [LW-1:0] len_i,
    input  logic [PW-1:0] pos_i,
    output logic [LW-1:0] best_o,
    output logic [PW-1:0] ip_o,
    output logic [LW-1:0] best_next_o
);

    typedef struct packed {
        logic [LW-1:0] best;
        logic [PW-1:0] ip;
    } best_state_t;

    best_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.best = '0;
            st_d.ip   = '0;
        end else if (upd_i && (len_i > st_q.best)) begin
            st_d.best = len_i;
            st_d.ip   = pos_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign best_o      = st_q.best;
    assign ip_o        = st_q.ip;
    assign best_next_o = st_d.best;

    // R4: without a clear the stored length never shrinks
    assert_best_monotonic_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> (best_o >= $past(best_o)));

    // R4: an equal length leaves the stored position untouched
    assert_tie_keeps_pos_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && (len_i <= best_o)) |=> $stable(ip_o));

    // R2: a clear empties the stored match
    assert_clear_empties_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (best_o == '0 && ip_o == '0));

endmodule

// File: rtl/lzmr_finish_ctl.sv
module lzmr_finish_ctl
    import lzmr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic last_i,
    input  logic full_i,
    output logic scan_o,
    output logic ready_o,
    output logic done_o
);

    typedef struct packed {
        scan_state_e scan;
        logic        ready;
        logic        done;
    } fin_state_t;

    fin_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.ready = 1'b0;
        st_d.done  = 1'b0;
        if (start_i) begin
            st_d.scan = SCAN_RUN;
        end else if (st_q.scan == SCAN_RUN) begin
            if (full_i) begin
                st_d.done = 1'b1;
            end
            if (last_i) begin
                st_d.ready = 1'b1;
            end
            if (full_i || last_i) begin
                st_d.scan = SCAN_IDLE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{scan: SCAN_IDLE, ready: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign scan_o  = (st_q.scan == SCAN_RUN);
    assign ready_o = st_q.ready;
    assign done_o  = st_q.done;

    // R8: each strobe lasts one cycle
    assert_ready_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |=> !ready_o);
    assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R8: a strobe always closes the search
    assert_strobe_closes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o || done_o) |-> !scan_o);

endmodule

// File: rtl/lzmr_top.sv
module lzmr_top #(
    parameter int DICT_LEN = 40,
    parameter int LOOK_LEN = 8,
    parameter int LW       = $clog2(LOOK_LEN) + 1,
    parameter int PW       = $clog2(DICT_LEN - LOOK_LEN + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [LW-1:0] len_i,
    output logic [PW-1:0] pos_o,
    output logic [LW-1:0] best_len_o,
    output logic          ready_o,
    output logic          done_o
);

    localparam int            LastPos = DICT_LEN - LOOK_LEN;
    localparam logic [LW-1:0] FullLen = LW'(LOOK_LEN);

    logic          scan;
    logic          take;
    logic          at_last;
    logic          full_hit;
    logic [PW-1:0] cnt;
    logic [LW-1:0] best_next;

    assign take     = scan && !start_i;
    assign full_hit = take && (best_next >= FullLen);

    lzmr_pos_count #(
        .LAST_POS (LastPos),
        .PW       (PW)
    ) u_pos (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (start_i),
        .step_i (take),
        .cnt_o  (cnt),
        .last_o (at_last)
    );

    lzmr_best_keep #(
        .LW (LW),
        .PW (PW)
    ) u_best (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clr_i       (start_i),
        .upd_i       (take),
        .len_i       (len_i),
        .pos_i       (cnt),
        .best_o      (best_len_o),
        .ip_o        (pos_o),
        .best_next_o (best_next)
    );

    lzmr_finish_ctl u_fin (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .last_i  (at_last),
        .full_i  (full_hit),
        .scan_o  (scan),
        .ready_o (ready_o),
        .done_o  (done_o)
    );

    // R6: an early stop only ever reports a full-length match
    assert_done_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (best_len_o == FullLen));

    // R5: ready without done means no full-length match was found
    assert_ready_partial_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o && !done_o) |-> (best_len_o < FullLen));

    // R8: while idle and not restarted, the codeword fields hold
    assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!scan && !start_i) |=> ($stable(best_len_o) && $stable(pos_o)));

    // R10: the stored pointer stays inside the window
    assert_pos_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pos_o <= PW'(LastPos));

endmodule

// File: tb/lzmr_top_tb_top.sv
module lzmr_top_tb_top;

    localparam int DL   = 40;
    localparam int LL   = 8;
    localparam int LW   = $clog2(LL) + 1;
    localparam int PW   = $clog2(DL - LL + 1);
    localparam int LAST = DL - LL;
    localparam int NV   = 8;

    // fields: pos_a, len_a, pos_b, len_b, exp_pos, exp_len, exp_done, exp_ready
    typedef int vec_t [8];
    localparam vec_t VECS [NV] = '{
        '{5,  3, 10, 3,  5,  3, 0, 1},   // tie keeps earliest (R4)
        '{5,  3, 10, 4, 10,  4, 0, 1},   // strictly greater wins (R4)
        '{7,  8, 20, 5,  7,  8, 1, 0},   // early full match (R6)
        '{32, 8, 0,  0, 32,  8, 1, 1},   // full match at last position (R7)
        '{0,  2, 32, 7, 32,  7, 0, 1},   // best at last position (R5)
        '{0,  0, 0,  0,  0,  0, 0, 1},   // all zero (R5)
        '{0,  8, 5,  8,  0,  8, 1, 0},   // full match at position 0 (R6)
        '{31, 7, 32, 6, 31,  7, 0, 1}    // later smaller ignored (R4)
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] len = '0;
    logic [PW-1:0] pos;
    logic [LW-1:0] best;
    logic          ready;
    logic          done;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lzmr_top #(.DICT_LEN(DL), .LOOK_LEN(LL)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .len_i      (len),
        .pos_o      (pos),
        .best_len_o (best),
        .ready_o    (ready),
        .done_o     (done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    function automatic int len_at(int k, int pa, int la, int pb, int lb);
        if (k == pa) return la;
        if (k == pb) return lb;
        return 0;
    endfunction

    task automatic pulse_start(input int start_len);
        @(negedge clk);
        start = 1'b1;
        len   = LW'(start_len);
        @(negedge clk);
        start = 1'b0;
        chk("R2 cleared len", int'(best), 0);
        chk("R2 cleared pos", int'(pos), 0);
    endtask

    task automatic run_vec(input int pa, input int la, input int pb, input int lb,
                           input int ep, input int el, input int ed, input int er);
        int term;
        int exp_term;
        term = -1;
        pulse_start(LL);
        for (int k = 0; k <= LAST; k++) begin
            len = LW'(len_at(k, pa, la, pb, lb));
            @(negedge clk);
            if (ready || done) begin
                term = k;
                break;
            end
        end
        exp_term = (ed != 0) ? ep : LAST;
        chk("R5/R6 strobe cycle", term, exp_term);
        chk("R6 done", int'(done), ed);
        chk("R5 ready", int'(ready), er);
        chk("R4 pos", int'(pos), ep);
        chk("R4 len", int'(best), el);
        // R8: strobes drop, further lengths ignored, fields hold
        for (int j = 0; j < 3; j++) begin
            len = LW'(LL);
            @(negedge clk);
            chk("R8 ready low", int'(ready), 0);
            chk("R8 done low", int'(done), 0);
            chk("R8 pos hold", int'(pos), ep);
            chk("R8 len hold", int'(best), el);
        end
        len = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 len", int'(best), 0);
        chk("R1 pos", int'(pos), 0);
        chk("R1 ready", int'(ready), 0);
        chk("R1 done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle ready", int'(ready), 0);

        // R10: port widths
        chk("R10 len width", $bits(best), LW);
        chk("R10 pos width", $bits(pos), PW);

        for (int v = 0; v < NV; v++) begin
            run_vec(VECS[v][0], VECS[v][1], VECS[v][2], VECS[v][3],
                    VECS[v][4], VECS[v][5], VECS[v][6], VECS[v][7]);
        end

        // R3: position tracking, a single length at each of several positions
        for (int p = 1; p < LAST; p += 9) begin
            run_vec(p, 5, -1, 0, p, 5, 0, 1);
        end

        // R9: restart in the middle of a search
        pulse_start(0);
        for (int k = 0; k < 4; k++) begin
            len = LW'((k == 2) ? 5 : 0);
            @(negedge clk);
        end
        chk("R9 before restart", int'(best), 5);
        run_vec(1, 3, -1, 0, 1, 3, 0, 1);

        // R2: the length present with start is ignored
        pulse_start(LL);
        chk("R2 no early done", int'(done), 0);

        finish_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

endmodule